// File: doc/BRIEF.md
# Daisy-Chain Interrupt Vector Controller

This block arbitrates and vectors the interrupts of a two-channel serial controller that sits on a daisy-chained interrupt bus. Eight interrupt sources feed it, four per channel: transmit buffer empty, external/status change, receive character available and special receive condition. Each source request is captured in a pending latch. An in-service latch per source records which interrupt the processor is servicing. The block drives an active-low interrupt request and takes part in the enable-in/enable-out priority chain shared with other devices on the bus.

On a hardware acknowledge the block puts an 8-bit vector on the data bus. The vector is a base value with a 3-bit source code written into it. The code goes into bits 3:1, or into bits 6:4 in reversed bit order. When software acknowledge is enabled, reading the status vector performs the same acknowledge internally. A control register holds five bits: master enable, chain disable, no-vector, status placement and software-acknowledge enable. A command input retires the highest-priority interrupt in service.

Top module: `irq_chain_vectorer`

## Requirements
- R1: After reset the control register is all zero. `int_n` is 1, `data_oe` is 0, no source is in service and `ieo` equals `iei`. A write with `ctl_we` loads `ctl_wd` into the control register: bit 0 is master enable, bit 1 is chain disable, bit 2 is no-vector, bit 3 is status-high placement and bit 4 is software-acknowledge enable.
- R2: Source codes are 000 B transmit empty, 001 B external/status, 010 B receive available, 011 B special receive, 100 A transmit empty, 101 A external/status, 110 A receive available and 111 A special receive. Bit n of `src_req` is the request of code n. A request shows at the outputs one clock after it is driven. With the low placement, code bits 2, 1 and 0 replace vector bits 3, 2 and 1, and the other vector bits come from `vec_base`.
- R3: With the high placement, code bits 2, 1 and 0 replace vector bits 4, 5 and 6, and the other vector bits come from `vec_base`.
- R4: When no source is eligible, the status field of the read vector holds code 011.
- R5: Priority runs from highest to lowest: 111, 110, 100, 101, 011, 010, 000, 001. The vector carries the highest-priority eligible source.
- R6: A source is eligible when it is pending and no source of equal or higher priority is in service. `int_n` is 0 exactly when master enable is set, `iei` is 1 and some source is eligible.
- R7: A hardware acknowledge is `intack` high while `iei` is 1, master enable is set and a source is eligible. It raises `data_oe` with the vector in the same cycle. At the next clock it sets the winner's in-service latch.
- R8: With no-vector set, `data_oe` stays 0 during an acknowledge, and the in-service latch is still set.
- R9: With software acknowledge enabled, a `rd_stat` read while master enable is set and a source is eligible sets the winner's in-service latch at the next clock. With software acknowledge disabled, the read leaves the latches unchanged.
- R10: `ieo` is 0 when chain disable is set or any source is in service. Otherwise `ieo` is `iei` gated low while master enable is set and any source is pending.
- R11: While master enable is clear, no in-service latch is set by any acknowledge.
- R12: A `rst_ius` pulse clears the highest-priority set in-service latch at the next clock and leaves the others set.
- R13: While `rd_raw` is 1, `data_out` returns `vec_base` unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 8 | Source requests, indexed by source code |
| vec_base | input | 8 | Base interrupt vector |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wd | input | 5 | Control register write data |
| iei | input | 1 | Chain enable in, from the higher-priority neighbour |
| intack | input | 1 | Hardware interrupt acknowledge strobe |
| rd_stat | input | 1 | Read strobe for the status-modified vector |
| rd_raw | input | 1 | Read select for the unmodified base vector |
| rst_ius | input | 1 | Command: retire the highest in-service interrupt |
| int_n | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Chain enable out, to the lower-priority neighbour |
| data_oe | output | 1 | Data bus drive enable during acknowledge |
| data_out | output | 8 | Vector or read data |

## Verification
The bench builds the block with its default package values: a 3-bit code, eight sources and an 8-bit vector. At these values every source code and both status placements can be reached exhaustively. Directed sequences walk all eight priority ranks, nested in-service states, acknowledges while a latch blocks requests and each control bit on its own. A behavioural model that scans an explicit priority list checks every output on every cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int CODE_W = 3;
  localparam int NSRC   = 1 << CODE_W;
  localparam int VEC_W  = 8;
  localparam int CTL_W  = 5;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // bit 0 = master enable ... bit 4 = software acknowledge enable
  typedef struct packed {
    logic swack_en;
    logic stat_hi;
    logic nv;
    logic dlc;
    logic mie;
  } ctl_t;

  localparam code_t IDLE_CODE = code_t'(3'b011);

  // Rank 0 is the highest priority. Within a channel: special > receive > transmit > external.
  function automatic code_t rank_code(input int r);
    logic chan_a;
    logic [1:0] kind;
    chan_a = (r < NSRC/2);
    case (r % (NSRC/2))
      0:       kind = 2'b11;
      1:       kind = 2'b10;
      2:       kind = 2'b00;
      default: kind = 2'b01;
    endcase
    return {chan_a, kind};
  endfunction

  // Write the source code into the base vector, low field or reversed high field.
  function automatic vec_t place_status(input vec_t base, input code_t c, input logic hi);
    vec_t v;
    v = base;
    if (hi) begin
      v[4] = c[2];
      v[5] = c[1];
      v[6] = c[0];
    end else begin
      v[3] = c[2];
      v[2] = c[1];
      v[1] = c[0];
    end
    return v;
  endfunction
endpackage

// File: rtl/irqv_ctl_reg.sv
module irqv_ctl_reg
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wd,
  output ctl_t             ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= ctl_t'(wd);
  end
endmodule

// File: rtl/irqv_latches.sv
module irqv_latches
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            set_en,
  input  code_t           set_code,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] ius_q
);
  logic [NSRC-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_code] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ius_q  <= '0;
    end else begin
      pend_q <= src_req;
      ius_q  <= (ius_q & ~clr_mask) | set_mask;
    end
  end
endmodule

// File: rtl/irqv_prio_scan.sv
module irqv_prio_scan
  import irqv_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] ius,
  output logic            any_elig,
  output code_t           win_code,
  output logic            any_ius,
  output logic [NSRC-1:0] top_ius_mask
);
  logic [NSRC:0]   blocked;
  logic [NSRC-1:0] elig_r;

  assign blocked[0] = 1'b0;

  for (genvar r = 0; r < NSRC; r++) begin : g_rank
    localparam code_t C = rank_code(r);
    assign elig_r[r]    = pend[C] & ~blocked[r] & ~ius[C];
    assign blocked[r+1] = blocked[r] | ius[C];
  end

  assign any_ius = blocked[NSRC];

  always_comb begin
    win_code = IDLE_CODE;
    any_elig = 1'b0;
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (elig_r[r]) begin
        win_code = rank_code(r);
        any_elig = 1'b1;
      end
    end
  end

  always_comb begin
    top_ius_mask = '0;
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (ius[rank_code(r)]) begin
        top_ius_mask = '0;
        top_ius_mask[rank_code(r)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqv_chain_out.sv
module irqv_chain_out
  import irqv_pkg::*;
(
  input  ctl_t  ctl,
  input  logic  iei,
  input  logic  intack,
  input  logic  rd_stat,
  input  logic  rd_raw,
  input  vec_t  vec_base,
  input  logic  any_elig,
  input  code_t win_code,
  input  logic  any_ius,
  input  logic  any_pend,
  output logic  int_n,
  output logic  ieo,
  output logic  data_oe,
  output vec_t  data_out,
  output logic  ack_evt
);
  logic ack_ok, hw_ack, sw_ack;

  assign ack_ok  = ctl.mie & any_elig;
  assign hw_ack  = intack & iei & ack_ok;
  assign sw_ack  = rd_stat & ctl.swack_en & ack_ok;
  assign ack_evt = hw_ack | sw_ack;

  assign int_n   = ~(ctl.mie & iei & any_elig);
  assign ieo     = ~ctl.dlc & ~any_ius & iei & ~(ctl.mie & any_pend);
  assign data_oe = hw_ack & ~ctl.nv;

  assign data_out = rd_raw ? vec_base : place_status(vec_base, win_code, ctl.stat_hi);
endmodule

// File: rtl/irq_chain_vectorer.sv
module irq_chain_vectorer
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic [VEC_W-1:0] vec_base,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             iei,
  input  logic             intack,
  input  logic             rd_stat,
  input  logic             rd_raw,
  input  logic             rst_ius,
  output logic             int_n,
  output logic             ieo,
  output logic             data_oe,
  output logic [VEC_W-1:0] data_out
);
  ctl_t            ctl_q;
  logic [NSRC-1:0] pend_q, ius_q, top_ius_mask, clr_mask;
  logic            any_elig, any_ius, ack_evt;
  code_t           win_code;

  // named internal events for the checker
  logic mie_q, dlc_q, nv_q;
  assign mie_q    = ctl_q.mie;
  assign dlc_q    = ctl_q.dlc;
  assign nv_q     = ctl_q.nv;
  assign clr_mask = rst_ius ? top_ius_mask : '0;

  irqv_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wd(ctl_wd), .ctl_q(ctl_q)
  );

  irqv_latches u_lat (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .set_en(ack_evt), .set_code(win_code), .clr_mask(clr_mask),
    .pend_q(pend_q), .ius_q(ius_q)
  );

  irqv_prio_scan u_scan (
    .pend(pend_q), .ius(ius_q), .any_elig(any_elig), .win_code(win_code),
    .any_ius(any_ius), .top_ius_mask(top_ius_mask)
  );

  irqv_chain_out u_out (
    .ctl(ctl_q), .iei(iei), .intack(intack), .rd_stat(rd_stat), .rd_raw(rd_raw),
    .vec_base(vec_base), .any_elig(any_elig), .win_code(win_code),
    .any_ius(any_ius), .any_pend(|pend_q),
    .int_n(int_n), .ieo(ieo), .data_oe(data_oe), .data_out(data_out),
    .ack_evt(ack_evt)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mie_q,
  input logic            dlc_q,
  input logic            nv_q,
  input logic [NSRC-1:0] ius_q,
  input logic            ack_evt,
  input code_t           win_code,
  input logic            rst_ius,
  input logic            int_n,
  input logic            ieo,
  input logic            data_oe
);
  p_dlc_ieo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dlc_q |-> !ieo);

  p_ius_ieo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_q) |-> !ieo);

  p_nv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_q |-> !data_oe);

  p_no_mie_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_q |-> int_n);

  p_ack_sets_ius_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> ius_q[$past(win_code)]);

  p_no_mie_no_ius_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_q |=> ((ius_q & ~$past(ius_q)) == '0));

  p_retire_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ius && !ack_evt && (|ius_q)) |=> ($countones(ius_q) == $countones($past(ius_q)) - 1));
endmodule

bind irq_chain_vectorer irqv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mie_q(mie_q), .dlc_q(dlc_q), .nv_q(nv_q),
  .ius_q(ius_q), .ack_evt(ack_evt), .win_code(win_code), .rst_ius(rst_ius),
  .int_n(int_n), .ieo(ieo), .data_oe(data_oe)
);

// File: tb/tb_irq_chain_vectorer.sv
`timescale 1ns/1ps
module tb_irq_chain_vectorer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_req = '0, vec_base = 8'hA5;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wd = '0;
  logic       iei = 1'b1, intack = 1'b0, rd_stat = 1'b0, rd_raw = 1'b0, rst_ius = 1'b0;
  logic       int_n, ieo, data_oe;
  logic [7:0] data_out;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_vectorer dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .vec_base(vec_base),
    .ctl_we(ctl_we), .ctl_wd(ctl_wd), .iei(iei), .intack(intack),
    .rd_stat(rd_stat), .rd_raw(rd_raw), .rst_ius(rst_ius),
    .int_n(int_n), .ieo(ieo), .data_oe(data_oe), .data_out(data_out)
  );

  // ---------------- behavioural reference model ----------------
  int prio [8] = '{7, 6, 4, 5, 3, 2, 0, 1};
  logic [7:0] m_pend = '0, m_ius = '0;
  bit m_mie, m_dlc, m_nv, m_hi, m_sw;

  function automatic int m_win();
    for (int i = 0; i < 8; i++) begin
      if (m_ius[prio[i]]) return -1;
      if (m_pend[prio[i]]) return prio[i];
    end
    return -1;
  endfunction

  function automatic logic [7:0] m_vec(input logic [7:0] b, input int c, input bit hi);
    int f;
    if (hi) begin
      f = ((c & 1) << 2) | (c & 2) | ((c >> 2) & 1);
      return (b & 8'h8F) | 8'(f << 4);
    end
    return (b & 8'hF1) | 8'(c << 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_ius = '0;
      {m_sw, m_hi, m_nv, m_dlc, m_mie} = '0;
    end else begin
      int w, top;
      logic [7:0] nxt;
      w = m_win();
      top = -1;
      for (int i = 0; i < 8; i++) if (top < 0 && m_ius[prio[i]]) top = prio[i];
      nxt = m_ius;
      if (rst_ius && top >= 0) nxt[top] = 1'b0;
      if (m_mie && w >= 0 && ((intack && iei) || (rd_stat && m_sw))) nxt[w] = 1'b1;
      m_ius = nxt;
      m_pend = src_req;
      if (ctl_we) {m_sw, m_hi, m_nv, m_dlc, m_mie} = ctl_wd;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int w;
      w = m_win();
      chk(cur_req, "model int_n", {7'b0, int_n}, {7'b0, !(m_mie && iei && w >= 0)});
      chk(cur_req, "model ieo", {7'b0, ieo},
          {7'b0, !m_dlc && iei && m_ius == 0 && !(m_mie && m_pend != 0)});
      chk(cur_req, "model data_oe", {7'b0, data_oe},
          {7'b0, intack && iei && m_mie && w >= 0 && !m_nv});
      chk(cur_req, "model data_out", data_out,
          rd_raw ? vec_base : m_vec(vec_base, (w >= 0) ? w : 3, m_hi));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); #2; endtask
  task automatic wr_ctl(input logic [4:0] v);
    ctl_we = 1'b1; ctl_wd = v; step(); ctl_we = 1'b0;
  endtask
  task automatic hw_ack(); intack = 1'b1; step(); intack = 1'b0; endtask
  task automatic retire(); rst_ius = 1'b1; step(); rst_ius = 1'b0; endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look();
    cur_req = "R1";
    chk("R1", "reset int_n", {7'b0, int_n}, 8'h01);
    chk("R1", "reset data_oe", {7'b0, data_oe}, 8'h00);
    chk("R1", "reset ieo", {7'b0, ieo}, 8'h01);
    src_req = 8'h01; step(); look();
    chk("R1", "master enable cleared by reset", {7'b0, int_n}, 8'h01);
    src_req = '0; step();

    cur_req = "R13";
    rd_raw = 1'b1; look();
    chk("R13", "raw read", data_out, 8'hA5);
    rd_raw = 1'b0;

    cur_req = "R4";
    look();
    chk("R4", "idle status code", data_out, 8'hA7);

    cur_req = "R6";
    wr_ctl(5'b00001);
    src_req = 8'h01; step(); look();
    chk("R6", "request asserts int_n", {7'b0, int_n}, 8'h00);
    chk("R10", "pending pulls ieo low", {7'b0, ieo}, 8'h00);
    chk("R2", "code 000 low field", data_out, 8'hA1);
    iei = 1'b0; look();
    chk("R6", "iei low blocks int_n", {7'b0, int_n}, 8'h01);
    iei = 1'b1;

    cur_req = "R5";
    for (int r = 0; r < 8; r++) begin
      logic [7:0] m;
      m = '0;
      for (int k = r; k < 8; k++) m[prio[k]] = 1'b1;
      src_req = m; step(); look();
      chk("R5", "priority winner", data_out, m_vec(8'hA5, prio[r], 1'b0));
    end

    cur_req = "R7";
    src_req = 8'hFF; step();
    intack = 1'b1; look();
    chk("R7", "ack drives bus", {7'b0, data_oe}, 8'h01);
    chk("R2", "code 111 low field", data_out, 8'hAF);
    step(); intack = 1'b0; look();
    chk("R7", "in service releases int_n", {7'b0, int_n}, 8'h01);
    chk("R10", "in service holds ieo low", {7'b0, ieo}, 8'h00);

    cur_req = "R12";
    retire(); look();
    chk("R12", "retire re-arms int_n", {7'b0, int_n}, 8'h00);

    cur_req = "R8";
    wr_ctl(5'b00101);
    intack = 1'b1; look();
    chk("R8", "no-vector keeps bus free", {7'b0, data_oe}, 8'h00);
    step(); intack = 1'b0; look();
    chk("R8", "ack still sets in-service", {7'b0, int_n}, 8'h01);
    retire();

    cur_req = "R9";
    wr_ctl(5'b10001);
    rd_stat = 1'b1; look();
    chk("R9", "status read vector", data_out, 8'hAF);
    step(); rd_stat = 1'b0; look();
    chk("R9", "software ack sets in-service", {7'b0, int_n}, 8'h01);
    retire();
    wr_ctl(5'b00001);
    rd_stat = 1'b1; step(); rd_stat = 1'b0; look();
    chk("R9", "read without soft ack ignored", {7'b0, int_n}, 8'h00);

    cur_req = "R3";
    wr_ctl(5'b01001);
    src_req = 8'h02; step(); look();
    chk("R3", "code 001 high field", data_out, 8'hC5);
    src_req = 8'h40; step(); look();
    chk("R3", "code 110 high field", data_out, 8'hB5);

    cur_req = "R11";
    wr_ctl(5'b00000);
    intack = 1'b1; look();
    chk("R11", "no bus drive with master off", {7'b0, data_oe}, 8'h00);
    step(); intack = 1'b0; look();
    chk("R11", "ieo follows iei, nothing in service", {7'b0, ieo}, 8'h01);
    wr_ctl(5'b00001); look();
    chk("R11", "request not in service", {7'b0, int_n}, 8'h00);

    cur_req = "R12";
    src_req = 8'h01; step(); step();
    hw_ack();
    src_req = 8'h80; step(); look();
    chk("R6", "higher source passes in-service lower", {7'b0, int_n}, 8'h00);
    hw_ack();
    src_req = 8'h00; step(); look();
    chk("R12", "two in service", {7'b0, ieo}, 8'h00);
    retire(); look();
    chk("R12", "lower still in service", {7'b0, ieo}, 8'h00);
    retire(); look();
    chk("R12", "all retired", {7'b0, ieo}, 8'h01);

    cur_req = "R10";
    wr_ctl(5'b00011); look();
    chk("R10", "chain disable forces ieo", {7'b0, ieo}, 8'h00);
    wr_ctl(5'b00001); look();
    chk("R10", "chain disable released", {7'b0, ieo}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule